// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the start-up and refresh duty for an asynchronous DRAM that shares its row strobe, column strobe, write enable and address pins with an access controller. Out of reset it waits out the power-up pause. It then borrows the pins through a request/grant handshake and runs a burst of initial refresh cycles. After the burst it raises a ready flag. From then on it asks for the pins once per refresh interval and runs one refresh cycle each time it is granted. A request that has to wait is kept: a refresh debt counter lets missed intervals be paid back one after another.

A parameter picks the refresh style. In counter style the column strobe falls first and the device supplies the row. In row style the column strobe stays high and the block drives its own 10-bit row, which wraps. The block can also put the device into its parallel test mode. It does this with a counter-style cycle that holds write enable low. Any plain refresh cycle takes the device back out. The block tracks the device's mode, so periodic refreshes made while in test mode keep write enable low and do not leave the mode by accident.

Every timing limit is a parameter in clock cycles: pause length, number of initial refreshes, refresh interval, column lead, row-active width and row precharge.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_ni is low and right after it is released, ras_n_o, cas_n_o and we_n_o are high, and req_o, ready_o and test_mode_o are low.
- R2: req_o first rises on the PAUSE_CYC-th rising clock edge after reset is released, never earlier.
- R3: Exactly INIT_REFS refresh cycles (row strobe pulses) are made after the pause and before ready_o rises. Once high, ready_o stays high until reset.
- R4: In counter style, cas_n_o falls exactly CAS_SU_CYC cycles before ras_n_o falls and stays low for the whole time ras_n_o is low. addr_o is all zeros at that point.
- R5: In row style, cas_n_o stays high during every refresh and addr_o carries the row counter. The counter starts at 0 after reset, goes up by one per refresh, wraps from 1023 to 0, and stays stable while ras_n_o is low.
- R6: Every row strobe pulse is exactly RAS_ACT_CYC cycles long. After the first pulse, each fall of ras_n_o comes at least RAS_PRE_CYC cycles after the previous rise.
- R7: After ready_o rises, with grant given at once, consecutive refresh cycles start exactly REF_INT_CYC cycles apart.
- R8: Strobes are driven low only while req_o is high. Once raised, req_o stays high until gnt_i has been received and the cycle is finished. Intervals that expire while the grant is withheld are not lost: after the grant comes, the next refresh follows with no interval wait.
- R9: A pulse on test_enter_i after ready makes the next refresh a counter-style cycle with we_n_o low from the fall of cas_n_o until ras_n_o rises. test_mode_o goes high when that cycle ends. Refreshes made while test_mode_o is high also hold we_n_o low.
- R10: A pulse on test_leave_i makes the next refresh a plain one (we_n_o high). test_mode_o goes low when that cycle ends. If both pulses arrive in the same cycle, leaving wins.
- R11: test_enter_i and test_leave_i are ignored while ready_o is low: test_mode_o stays low and the first refresh after ready keeps we_n_o high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Arbiter grant of the shared DRAM pins |
| test_enter_i | input | 1 | Pulse: enter device test mode |
| test_leave_i | input | 1 | Pulse: return device to normal mode |
| req_o | output | 1 | Request for the shared DRAM pins |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ROW_W | Refresh row address (row style), zero otherwise |
| ready_o | output | 1 | Initialisation done, normal access allowed |
| test_mode_o | output | 1 | Device is believed to be in test mode |

## Verification
The bench measures every row strobe pulse: its width, the column lead before it and the precharge gap before it. A wrong counter bound therefore shows up as a pulse one cycle too short or too long, or as a column strobe that falls together with the row strobe and gives a row-style refresh instead of a counter one. It withholds the grant for longer than a refresh interval to show that a design which drops requests would wait a full interval before the next refresh. Test-mode requests are sent during the pause, where a design that listened would leave the device in test mode. Entry and exit are also interleaved with plain refreshes, where a design that forgot the mode would drop out of test mode on the next periodic cycle. A second instance in row style runs past 1024 refreshes to show that the address wraps to zero and never repeats or skips a row.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE  = 3'd0,
    ST_IDLE   = 3'd1,
    ST_REQ    = 3'd2,
    ST_CAS_SU = 3'd3,
    ST_ACT    = 3'd4,
    ST_PRE    = 3'd5
  } seq_state_e;

  typedef enum logic {
    RF_CBR = 1'b0,
    RF_ROW = 1'b1
  } ref_mode_e;
endpackage

// File: rtl/drs_interval.sv
module drs_interval #(
  parameter int INT_CYC  = 1950,
  parameter int PEND_MAX = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic done_i,
  output logic pend_o
);
  localparam int TW = $clog2(INT_CYC);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [TW-1:0] tick_q;
  logic [PW-1:0] pend_q;
  logic          tick;
  logic          pay;

  assign tick = en_i && (tick_q == TW'(INT_CYC - 1));
  assign pay  = done_i && (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tick_q <= '0;
    else if (!en_i)   tick_q <= '0;
    else if (tick)    tick_q <= '0;
    else              tick_q <= tick_q + 1'b1;
  end

  // refresh debt: saturating, never dropped below real demand
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else begin
      case ({tick, pay})
        2'b10:   if (pend_q != PW'(PEND_MAX)) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign pend_o = (pend_q != '0);
endmodule

// File: rtl/drs_test_ctl.sv
module drs_test_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic enter_i,
  input  logic leave_i,
  input  logic done_i,
  input  logic done_wcbr_i,
  output logic want_o,
  output logic mode_o
);
  logic want_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       want_q <= 1'b0;
    else if (!ready_i) want_q <= 1'b0;
    else if (leave_i)  want_q <= 1'b0;
    else if (enter_i)  want_q <= 1'b1;
  end

  // device mode follows the kind of the last completed cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= 1'b0;
    else if (done_i) mode_q <= done_wcbr_i;
  end

  assign want_o = want_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/drs_row_ctr.sv
module drs_row_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (inc_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;
endmodule

// File: rtl/drs_seq_fsm.sv
module drs_seq_fsm
  import drs_pkg::*;
#(
  parameter ref_mode_e REF_MODE    = RF_CBR,
  parameter int        PAUSE_CYC   = 25000,
  parameter int        INIT_REFS   = 8,
  parameter int        CAS_SU_CYC  = 2,
  parameter int        RAS_ACT_CYC = 9,
  parameter int        RAS_PRE_CYC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  input  logic cyc_req_i,
  input  logic want_test_i,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic ready_o,
  output logic done_o,
  output logic done_wcbr_o
);
  localparam int M1    = (PAUSE_CYC > RAS_ACT_CYC) ? PAUSE_CYC : RAS_ACT_CYC;
  localparam int M2    = (RAS_PRE_CYC > CAS_SU_CYC) ? RAS_PRE_CYC : CAS_SU_CYC;
  localparam int MAXC  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int INI_W = $clog2(INIT_REFS + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [INI_W-1:0] init_q, init_d;
  logic             ready_q, ready_d;
  logic             cbr_q, cbr_d;
  logic             wcbr_q, wcbr_d;
  logic             last;

  always_comb begin
    case (state_q)
      ST_PAUSE:  last = (cnt_q == CNT_W'(PAUSE_CYC - 1));
      ST_CAS_SU: last = (cnt_q == CNT_W'(CAS_SU_CYC - 1));
      ST_ACT:    last = (cnt_q == CNT_W'(RAS_ACT_CYC - 1));
      ST_PRE:    last = (cnt_q == CNT_W'(RAS_PRE_CYC - 1));
      default:   last = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    init_d  = init_q;
    ready_d = ready_q;
    cbr_d   = cbr_q;
    wcbr_d  = wcbr_q;
    case (state_q)
      ST_PAUSE: if (last) begin
        state_d = ST_REQ;
        cnt_d   = '0;
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (cyc_req_i) state_d = ST_REQ;
      end
      ST_REQ: begin
        cnt_d = '0;
        if (gnt_i) begin
          wcbr_d  = ready_q && want_test_i;
          cbr_d   = (REF_MODE == RF_CBR) || (ready_q && want_test_i);
          state_d = cbr_d ? ST_CAS_SU : ST_ACT;
        end
      end
      ST_CAS_SU: if (last) begin
        state_d = ST_ACT;
        cnt_d   = '0;
      end
      ST_ACT: if (last) begin
        state_d = ST_PRE;
        cnt_d   = '0;
      end
      ST_PRE: if (last) begin
        cnt_d = '0;
        if (ready_q) state_d = ST_IDLE;
        else if (init_q == INI_W'(1)) begin
          ready_d = 1'b1;
          state_d = ST_IDLE;
        end else begin
          init_d  = init_q - 1'b1;
          state_d = ST_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      cnt_q   <= '0;
      init_q  <= INI_W'(INIT_REFS);
      ready_q <= 1'b0;
      cbr_q   <= 1'b0;
      wcbr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      init_q  <= init_d;
      ready_q <= ready_d;
      cbr_q   <= cbr_d;
      wcbr_q  <= wcbr_d;
    end
  end

  assign req_o       = (state_q == ST_REQ) || (state_q == ST_CAS_SU) ||
                       (state_q == ST_ACT) || (state_q == ST_PRE);
  assign ras_n_o     = (state_q != ST_ACT);
  assign cas_n_o     = !((state_q == ST_CAS_SU) || ((state_q == ST_ACT) && cbr_q));
  assign we_n_o      = !(wcbr_q && ((state_q == ST_CAS_SU) || (state_q == ST_ACT)));
  assign ready_o     = ready_q;
  assign done_o      = (state_q == ST_PRE) && last;
  assign done_wcbr_o = wcbr_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter ref_mode_e REF_MODE    = RF_CBR,
  parameter int        ROW_W       = 10,
  parameter int        PAUSE_CYC   = 25000,
  parameter int        INIT_REFS   = 8,
  parameter int        REF_INT_CYC = 1950,
  parameter int        CAS_SU_CYC  = 2,
  parameter int        RAS_ACT_CYC = 9,
  parameter int        RAS_PRE_CYC = 7,
  parameter int        PEND_MAX    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_i,
  input  logic             test_enter_i,
  input  logic             test_leave_i,
  output logic             req_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             ready_o,
  output logic             test_mode_o
);
  logic pend, want, mode, done, done_wcbr, cyc_req;

  assign cyc_req = pend || (want != mode);

  drs_interval #(
    .INT_CYC (REF_INT_CYC),
    .PEND_MAX(PEND_MAX)
  ) i_interval (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ready_o),
    .done_i(done && ready_o),
    .pend_o(pend)
  );

  drs_test_ctl i_test_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (ready_o),
    .enter_i    (test_enter_i),
    .leave_i    (test_leave_i),
    .done_i     (done),
    .done_wcbr_i(done_wcbr),
    .want_o     (want),
    .mode_o     (mode)
  );

  drs_seq_fsm #(
    .REF_MODE   (REF_MODE),
    .PAUSE_CYC  (PAUSE_CYC),
    .INIT_REFS  (INIT_REFS),
    .CAS_SU_CYC (CAS_SU_CYC),
    .RAS_ACT_CYC(RAS_ACT_CYC),
    .RAS_PRE_CYC(RAS_PRE_CYC)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gnt_i      (gnt_i),
    .cyc_req_i  (cyc_req),
    .want_test_i(want),
    .req_o      (req_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .we_n_o     (we_n_o),
    .ready_o    (ready_o),
    .done_o     (done),
    .done_wcbr_o(done_wcbr)
  );

  generate
    if (REF_MODE == RF_ROW) begin : g_row
      drs_row_ctr #(.ROW_W(ROW_W)) i_row (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .inc_i (done && !done_wcbr),
        .row_o (addr_o)
      );
    end else begin : g_cbr
      assign addr_o = '0;
    end
  endgenerate

  assign test_mode_o = mode;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int ROW_W       = 10,
  parameter int RAS_ACT_CYC = 9,
  parameter int RAS_PRE_CYC = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gnt_i,
  input logic             req_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic [ROW_W-1:0] addr_o,
  input logic             ready_o,
  input logic             test_mode_o
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= ras_n_o ? '0 : ((lo_cnt == 16'hffff) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !ras_n_o ? '0 : ((hi_cnt == 16'hffff) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  // R6
  ras_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_cnt == 16'(RAS_ACT_CYC)));
  // R6
  ras_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_cnt >= 16'(RAS_PRE_CYC)));
  // R4
  cas_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cas_n_o) |-> $past(!cas_n_o));
  // R8
  strobe_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o || !we_n_o) |-> req_o);
  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> req_o);
  // R3
  ready_stick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  // R11
  tm_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !test_mode_o);
  // R9
  we_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> !cas_n_o);
  // R5
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && $past(!ras_n_o)) |-> $stable(addr_o));
endmodule

bind dram_refresh_seq drs_checker #(
  .ROW_W      (ROW_W),
  .RAS_ACT_CYC(RAS_ACT_CYC),
  .RAS_PRE_CYC(RAS_PRE_CYC)
) i_drs_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gnt_i      (gnt_i),
  .req_o      (req_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .addr_o     (addr_o),
  .ready_o    (ready_o),
  .test_mode_o(test_mode_o)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  import drs_pkg::*;

  localparam int P    = 60;
  localparam int INI  = 8;
  localparam int INT  = 40;
  localparam int CSU  = 2;
  localparam int ACT  = 9;
  localparam int PRE  = 7;
  localparam int RW   = 10;

  // {delay[7:0], op[1:0] (0 none,1 enter,2 leave), exp_we_low, exp_tm}
  localparam logic [11:0] TBL [8] = '{
    {8'd0,   2'd0, 1'b0, 1'b0},
    {8'd4,   2'd1, 1'b1, 1'b1},
    {8'd0,   2'd0, 1'b1, 1'b1},
    {8'd100, 2'd0, 1'b1, 1'b1},
    {8'd2,   2'd2, 1'b0, 1'b0},
    {8'd0,   2'd0, 1'b0, 1'b0},
    {8'd0,   2'd1, 1'b1, 1'b1},
    {8'd7,   2'd3, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic gnt_a = 1'b0, gnt_b = 1'b0, block = 1'b0;
  logic ent_a = 1'b0, lv_a = 1'b0;
  logic req_a, ras_a, cas_a, we_a, rdy_a, tm_a;
  logic req_b, ras_b, cas_b, we_b, rdy_b, tm_b;
  logic [RW-1:0] addr_a, addr_b;

  dram_refresh_seq #(
    .REF_MODE(RF_CBR), .ROW_W(RW), .PAUSE_CYC(P), .INIT_REFS(INI),
    .REF_INT_CYC(INT), .CAS_SU_CYC(CSU), .RAS_ACT_CYC(ACT), .RAS_PRE_CYC(PRE)
  ) i_dram_refresh_seq (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt_a), .test_enter_i(ent_a),
    .test_leave_i(lv_a), .req_o(req_a), .ras_n_o(ras_a), .cas_n_o(cas_a),
    .we_n_o(we_a), .addr_o(addr_a), .ready_o(rdy_a), .test_mode_o(tm_a)
  );

  dram_refresh_seq #(
    .REF_MODE(RF_ROW), .ROW_W(RW), .PAUSE_CYC(P), .INIT_REFS(INI),
    .REF_INT_CYC(INT), .CAS_SU_CYC(CSU), .RAS_ACT_CYC(ACT), .RAS_PRE_CYC(PRE)
  ) i_dram_refresh_seq_row (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt_b), .test_enter_i(1'b0),
    .test_leave_i(1'b0), .req_o(req_b), .ras_n_o(ras_b), .cas_n_o(cas_b),
    .we_n_o(we_b), .addr_o(addr_b), .ready_o(rdy_b), .test_mode_o(tm_b)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nclk();
    @(negedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    gnt_a <= req_a && !block;
    gnt_b <= req_b;
  end

  // pulse monitor, counter-style instance
  int  cyc = 0;
  bit  a_prev_ras = 1'b1;
  int  a_cas_run = 0, a_hi_run = 0, a_lo_run = 0, a_pulses = 0;
  int  a_last_fall = 0, a_prev_fall = 0;
  bit  a_we_all = 1'b0, a_cas_all = 1'b0, a_last_we_low = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (a_prev_ras && !ras_a) begin
        chk(a_cas_run == CSU, "R4 cas lead", a_cas_run, CSU);
        chk(addr_a == '0, "R4 addr zero", int'(addr_a), 0);
        if (a_pulses > 0) chk(a_hi_run >= PRE, "R6 precharge", a_hi_run, PRE);
        a_prev_fall = a_last_fall;
        a_last_fall = cyc;
        a_we_all    = !we_a;
        a_cas_all   = !cas_a;
        a_lo_run    = 1;
      end else if (!a_prev_ras && !ras_a) begin
        a_lo_run++;
        a_we_all  = a_we_all && !we_a;
        a_cas_all = a_cas_all && !cas_a;
      end else if (!a_prev_ras && ras_a) begin
        chk(a_lo_run == ACT, "R6 ras width", a_lo_run, ACT);
        chk(a_cas_all, "R4 cas low under ras", int'(a_cas_all), 1);
        a_last_we_low = a_we_all;
        a_pulses++;
        a_hi_run = 1;
      end else begin
        a_hi_run++;
      end
      a_cas_run  = cas_a ? 0 : a_cas_run + 1;
      a_prev_ras = ras_a;
    end
  end

  // pulse monitor, row-style instance
  bit b_prev_ras = 1'b1;
  int b_pulses = 0, b_exp_row = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (b_prev_ras && !ras_b) begin
        chk(cas_b == 1'b1, "R5 cas high", int'(cas_b), 1);
        chk(int'(addr_b) == b_exp_row, "R5 row address", int'(addr_b), b_exp_row);
        if (b_pulses == 1024) chk(addr_b == '0, "R5 wrap", int'(addr_b), 0);
        b_exp_row = (b_exp_row + 1) % 1024;
        b_pulses++;
      end
      b_prev_ras = ras_b;
    end
  end

  task automatic wait_pulses(input int n);
    int p0;
    p0 = a_pulses;
    while (a_pulses < p0 + n) nclk();
  endtask

  initial begin
    int lows;
    nclk();
    // R1 reset state
    repeat (4) nclk();
    chk({ras_a, cas_a, we_a} == 3'b111, "R1 strobes in reset", int'({ras_a, cas_a, we_a}), 7);
    chk({req_a, rdy_a, tm_a} == 3'b000, "R1 flags in reset", int'({req_a, rdy_a, tm_a}), 0);
    rst_n = 1'b1;
    nclk();
    chk({ras_a, cas_a, we_a, req_a} == 4'b1110, "R1 after release", int'({ras_a, cas_a, we_a, req_a}), 14);
    lows = 1;
    // R2 pause, R11 requests during pause
    while (!req_a) begin
      ent_a = (lows == 10);
      nclk();
      if (!req_a) lows++;
    end
    ent_a = 1'b0;
    chk(lows == P - 1, "R2 pause length", lows, P - 1);
    while (!rdy_a) nclk();
    chk(a_pulses == INI, "R3 init refresh count", a_pulses, INI);
    chk(tm_a == 1'b0, "R11 test mode after init", int'(tm_a), 0);
    wait_pulses(1);
    chk(a_last_we_low == 1'b0, "R11 first refresh plain", int'(a_last_we_low), 0);
    wait_pulses(2);
    chk(a_last_fall - a_prev_fall == INT, "R7 interval", a_last_fall - a_prev_fall, INT);

    foreach (TBL[i]) begin
      int  dly;
      int  op;
      bit  ok_hi;
      dly = int'(TBL[i][11:4]);
      op  = int'(TBL[i][3:2]);
      while (req_a || !ras_a) nclk();
      block = 1'b1;
      ent_a = (op == 1) || (op == 3);
      lv_a  = (op == 2) || (op == 3);
      nclk();
      ent_a = 1'b0;
      lv_a  = 1'b0;
      while (!req_a) nclk();
      ok_hi = 1'b1;
      for (int k = 0; k < dly; k++) begin
        nclk();
        if (!(ras_a && cas_a && we_a && req_a)) ok_hi = 1'b0;
      end
      chk(ok_hi, "R8 idle while ungranted", int'(ok_hi), 1);
      block = 1'b0;
      wait_pulses(1);
      chk(a_last_we_low == TBL[i][1], "R9 R10 write enable level", int'(a_last_we_low), int'(TBL[i][1]));
      while (req_a) nclk();
      chk(tm_a == TBL[i][0], "R9 R10 test mode flag", int'(tm_a), int'(TBL[i][0]));
      if (dly >= INT) begin
        wait_pulses(1);
        chk(a_last_fall - a_prev_fall < INT, "R8 debt kept", a_last_fall - a_prev_fall, INT);
      end
    end

    while (b_pulses < 1026) nclk();
    chk(tm_b == 1'b0 && we_b == 1'b1, "R5 row instance plain", int'(tm_b), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule